// File: doc/BRIEF.md
# Bridge Link Self-Test Sequencer

This block is a host-side hardware sequencer that proves a parallel-port bridge link before the link is used. On a start pulse it runs two register loopback passes, then one pattern block read. It drives a generic register-access request port and a block-read request port, and a responder model stands in for the far side of the link.

Each loopback pass first writes a configuration value to index 6 of the register file. It then walks a counter k from 0 to 255. For each k it writes two patterned bytes to indices 2 and 3 and reads index 2 back. A read-back that does not match counts as an error for that pass. After both passes it requests a 512-byte block from address 0x10. Of that block only the first 128 bytes are checked, each against its own position. A single-cycle done pulse then reports a pass/fail verdict with all three error counts. The link fails when the block check finds any mismatch, or when both passes saw errors. One noisy pass on its own is tolerated.

Register requests use a level handshake. The request and its fields stay up until a one-cycle done pulse completes the request. The next request may be presented on the very next cycle.

Top module: `link_selftest_seq`

## Requirements
- R1: The run makes two passes, j=0 then j=1. Each pass opens with a write of 0xA0+0x10*j to register index 6. Every register access has space select 0 (register file).
- R2: In each pass, for k=0..255 in order, the block writes k^0xAA to index 2, writes k^0x55 to index 3, and then reads index 2 (reg_we_o=0). A run therefore makes exactly 1538 register accesses. A request holds its fields stable until reg_done_i.
- R3: A pass's 9-bit error counter increments when reg_rdata_i, sampled with reg_done_i on the read, differs from k^0xAA. The counter can reach 256 without wrapping.
- R4: After both passes complete, blk_req_o pulses for one cycle with blk_addr_o=0x10 and blk_len_o=512. No register request is raised while the block is being received.
- R5: Each byte accepted with blk_valid_i takes the next position, starting at 0. A byte at a position below 128 that differs from the low 8 bits of its position increments err_blk_o. Bytes at positions 128..511 have no effect on any count.
- R6: When done_o is high, fail_o is 1 exactly when err_blk_o is nonzero, or when err_pass0_o and err_pass1_o are both nonzero.
- R7: start_i in idle raises busy_o on the next cycle and clears all counters. done_o is a one-cycle pulse after the 512th block byte, in the cycle busy_o falls. The counters and fail_o then hold until the next start.
- R8: A start_i pulse while busy_o is high is ignored. The running sequence neither restarts nor produces an extra done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Link verdict, valid with done_o and held afterwards |
| err_pass0_o | output | 9 | Loopback error count, pass 0 |
| err_pass1_o | output | 9 | Loopback error count, pass 1 |
| err_blk_o | output | 9 | Block pattern mismatch count |
| reg_req_o | output | 1 | Register access request, held until done |
| reg_we_o | output | 1 | 1 = write, 0 = read |
| reg_space_o | output | 1 | Space select, 0 = register file |
| reg_idx_o | output | 4 | Register index |
| reg_wdata_o | output | 8 | Write data |
| reg_done_i | input | 1 | Completion pulse for the presented request |
| reg_rdata_i | input | 8 | Read data, valid with reg_done_i |
| blk_req_o | output | 1 | One-cycle block read request |
| blk_addr_o | output | 8 | Block source address |
| blk_len_o | output | 10 | Block length in bytes |
| blk_valid_i | input | 1 | Block byte strobe |
| blk_data_i | input | 8 | Block byte |

## Verification
Several internal faults show up at the ports as a wrong position in the access stream within a few cycles of the fault:
- A wrong pass or iteration counter.
- A skipped configuration write.
- A restart caused by a start pulse during a run.

The responder model compares every request against the expected stream as it is served. Faults in counting only show at done_o: a miscounted mismatch, a counter that wraps at 256, or a comparison window that reaches past byte 127. The scoreboard compares each count against values derived from the injected fault masks. Each run injects different fault masks, response latencies and byte gaps. A phase machine that loses its place shows either as an overlap of block and register requests or as a missing or extra done pulse.

// File: rtl/lst_pkg.sv
package lst_pkg;
  localparam int unsigned N_PASS = 2;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_CFG,
    RS_WRA,
    RS_WRB,
    RS_RD
  } reg_st_e;

  typedef enum logic [1:0] {
    CTL_IDLE,
    CTL_REG,
    CTL_BLK
  } ctl_st_e;

  typedef enum logic [1:0] {
    BS_IDLE,
    BS_REQ,
    BS_RECV
  } blk_st_e;
endpackage

// File: rtl/lst_reg_engine.sv
module lst_reg_engine
  import lst_pkg::*;
#(
  parameter int unsigned N_ITER = 256,
  parameter int unsigned CNT_W = 9,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned DAT_W = 8,
  parameter logic [IDX_W-1:0] CFG_IDX = 4'd6,
  parameter logic [IDX_W-1:0] IDX_A = 4'd2,
  parameter logic [IDX_W-1:0] IDX_B = 4'd3,
  parameter logic [DAT_W-1:0] PAT_A = 8'hAA,
  parameter logic [DAT_W-1:0] PAT_B = 8'h55,
  parameter logic [DAT_W-1:0] CFG_BASE = 8'hA0,
  parameter logic [DAT_W-1:0] CFG_STEP = 8'h10
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         go_i,
  input  logic                         reg_done_i,
  input  logic [DAT_W-1:0]             reg_rdata_i,
  output logic                         reg_req_o,
  output logic                         reg_we_o,
  output logic [IDX_W-1:0]             reg_idx_o,
  output logic [DAT_W-1:0]             reg_wdata_o,
  output logic [N_PASS-1:0][CNT_W-1:0] err_o,
  output logic                         fin_o
);
  localparam int unsigned K_W = (N_ITER > 1) ? $clog2(N_ITER) : 1;
  localparam int unsigned P_W = (N_PASS > 1) ? $clog2(N_PASS) : 1;
  localparam logic [K_W-1:0] K_LAST = K_W'(N_ITER - 1);
  localparam logic [P_W-1:0] P_LAST = P_W'(N_PASS - 1);

  reg_st_e          state_q;
  logic [K_W-1:0]   k_q;
  logic [P_W-1:0]   pass_q;
  logic [DAT_W-1:0] kd, expect_rd;
  logic             rd_hit, mismatch;

  assign kd        = DAT_W'(k_q);
  assign expect_rd = kd ^ PAT_A;
  assign rd_hit    = (state_q == RS_RD) && reg_done_i;
  assign mismatch  = rd_hit && (reg_rdata_i != expect_rd);
  assign fin_o     = rd_hit && (k_q == K_LAST) && (pass_q == P_LAST);
  assign reg_req_o = (state_q != RS_IDLE);

  always_comb begin
    reg_we_o    = 1'b1;
    reg_idx_o   = CFG_IDX;
    reg_wdata_o = CFG_BASE + (CFG_STEP * DAT_W'(pass_q));
    unique case (state_q)
      RS_CFG: ;
      RS_WRA: begin
        reg_idx_o   = IDX_A;
        reg_wdata_o = kd ^ PAT_A;
      end
      RS_WRB: begin
        reg_idx_o   = IDX_B;
        reg_wdata_o = kd ^ PAT_B;
      end
      RS_RD: begin
        reg_we_o    = 1'b0;
        reg_idx_o   = IDX_A;
        reg_wdata_o = '0;
      end
      default: begin
        reg_we_o    = 1'b0;
        reg_idx_o   = '0;
        reg_wdata_o = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RS_IDLE;
      k_q     <= '0;
      pass_q  <= '0;
    end else if (go_i) begin
      state_q <= RS_CFG;
      k_q     <= '0;
      pass_q  <= '0;
    end else if (reg_done_i) begin
      unique case (state_q)
        RS_CFG: state_q <= RS_WRA;
        RS_WRA: state_q <= RS_WRB;
        RS_WRB: state_q <= RS_RD;
        RS_RD: begin
          if (k_q != K_LAST) begin
            k_q     <= k_q + 1'b1;
            state_q <= RS_WRA;
          end else if (pass_q != P_LAST) begin
            k_q     <= '0;
            pass_q  <= pass_q + 1'b1;
            state_q <= RS_CFG;
          end else begin
            state_q <= RS_IDLE;
          end
        end
        default: state_q <= RS_IDLE;
      endcase
    end
  end

  for (genvar p = 0; p < N_PASS; p++) begin : g_err
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             err_o[p] <= '0;
      else if (go_i)                           err_o[p] <= '0;
      else if (mismatch && pass_q == P_W'(p))  err_o[p] <= err_o[p] + 1'b1;
    end
  end
endmodule

// File: rtl/lst_blk_checker.sv
module lst_blk_checker
  import lst_pkg::*;
#(
  parameter int unsigned BLK_LEN = 512,
  parameter int unsigned CHK_LEN = 128,
  parameter int unsigned CNT_W = 9,
  parameter int unsigned DAT_W = 8,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BLK_ADDR = 8'h10,
  localparam int unsigned LEN_W = $clog2(BLK_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              go_i,
  input  logic              blk_valid_i,
  input  logic [DAT_W-1:0]  blk_data_i,
  output logic              blk_req_o,
  output logic [ADDR_W-1:0] blk_addr_o,
  output logic [LEN_W-1:0]  blk_len_o,
  output logic [CNT_W-1:0]  err_o,
  output logic              fin_o
);
  localparam int unsigned POS_W = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1;
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(BLK_LEN - 1);

  blk_st_e          state_q;
  logic [POS_W-1:0] pos_q;
  logic             take, in_win;

  assign take       = (state_q == BS_RECV) && blk_valid_i;
  assign in_win     = ({1'b0, pos_q} < (POS_W + 1)'(CHK_LEN));
  assign fin_o      = take && (pos_q == POS_LAST);
  assign blk_req_o  = (state_q == BS_REQ);
  assign blk_addr_o = BLK_ADDR;
  assign blk_len_o  = LEN_W'(BLK_LEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BS_IDLE;
      pos_q   <= '0;
    end else begin
      unique case (state_q)
        BS_IDLE: if (go_i) begin
          state_q <= BS_REQ;
          pos_q   <= '0;
        end
        BS_REQ:  state_q <= BS_RECV;
        BS_RECV: if (take) begin
          pos_q <= pos_q + 1'b1;
          if (pos_q == POS_LAST) state_q <= BS_IDLE;
        end
        default: state_q <= BS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_o <= '0;
    else if (clr_i)  err_o <= '0;
    else if (take && in_win && blk_data_i != DAT_W'(pos_q)) err_o <= err_o + 1'b1;
  end
endmodule

// File: rtl/lst_ctrl.sv
module lst_ctrl
  import lst_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic reg_fin_i,
  input  logic blk_fin_i,
  output logic reg_go_o,
  output logic blk_go_o,
  output logic busy_o,
  output logic done_o
);
  ctl_st_e state_q;
  logic    done_q;

  assign reg_go_o = start_i && (state_q == CTL_IDLE);
  assign blk_go_o = reg_fin_i && (state_q == CTL_REG);
  assign busy_o   = (state_q != CTL_IDLE);
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CTL_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        CTL_IDLE: if (start_i)   state_q <= CTL_REG;
        CTL_REG:  if (reg_fin_i) state_q <= CTL_BLK;
        CTL_BLK:  if (blk_fin_i) begin
          state_q <= CTL_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= CTL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/link_selftest_seq.sv
module link_selftest_seq
  import lst_pkg::*;
#(
  parameter int unsigned N_ITER = 256,
  parameter int unsigned CNT_W = 9,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned DAT_W = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BLK_LEN = 512,
  parameter int unsigned CHK_LEN = 128,
  parameter logic [ADDR_W-1:0] BLK_ADDR = 8'h10,
  localparam int unsigned LEN_W = $clog2(BLK_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [CNT_W-1:0]  err_pass0_o,
  output logic [CNT_W-1:0]  err_pass1_o,
  output logic [CNT_W-1:0]  err_blk_o,
  output logic              reg_req_o,
  output logic              reg_we_o,
  output logic              reg_space_o,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic [DAT_W-1:0]  reg_wdata_o,
  input  logic              reg_done_i,
  input  logic [DAT_W-1:0]  reg_rdata_i,
  output logic              blk_req_o,
  output logic [ADDR_W-1:0] blk_addr_o,
  output logic [LEN_W-1:0]  blk_len_o,
  input  logic              blk_valid_i,
  input  logic [DAT_W-1:0]  blk_data_i
);
  logic reg_go, blk_go, reg_fin, blk_fin;
  logic [N_PASS-1:0][CNT_W-1:0] pass_err;
  logic [N_PASS-1:0]            pass_bad;

  lst_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .reg_fin_i (reg_fin),
    .blk_fin_i (blk_fin),
    .reg_go_o  (reg_go),
    .blk_go_o  (blk_go),
    .busy_o,
    .done_o
  );

  lst_reg_engine #(
    .N_ITER (N_ITER), .CNT_W (CNT_W), .IDX_W (IDX_W), .DAT_W (DAT_W)
  ) u_reg (
    .clk_i, .rst_ni,
    .go_i (reg_go),
    .reg_done_i, .reg_rdata_i,
    .reg_req_o, .reg_we_o, .reg_idx_o, .reg_wdata_o,
    .err_o (pass_err),
    .fin_o (reg_fin)
  );

  lst_blk_checker #(
    .BLK_LEN (BLK_LEN), .CHK_LEN (CHK_LEN), .CNT_W (CNT_W),
    .DAT_W (DAT_W), .ADDR_W (ADDR_W), .BLK_ADDR (BLK_ADDR)
  ) u_blk (
    .clk_i, .rst_ni,
    .clr_i (reg_go),
    .go_i  (blk_go),
    .blk_valid_i, .blk_data_i,
    .blk_req_o, .blk_addr_o, .blk_len_o,
    .err_o (err_blk_o),
    .fin_o (blk_fin)
  );

  for (genvar p = 0; p < N_PASS; p++) begin : g_bad
    assign pass_bad[p] = (pass_err[p] != '0);
  end

  // Failing needs every loopback pass to have seen errors, or any block mismatch.
  assign fail_o      = (err_blk_o != '0) || (&pass_bad);
  assign err_pass0_o = pass_err[0];
  assign err_pass1_o = pass_err[1];
  assign reg_space_o = 1'b0;
endmodule

// File: rtl/lst_chk.sv
module lst_chk #(
  parameter int unsigned CNT_W = 9,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned DAT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [CNT_W-1:0] err_pass0_o,
  input logic [CNT_W-1:0] err_pass1_o,
  input logic [CNT_W-1:0] err_blk_o,
  input logic             reg_req_o,
  input logic             reg_we_o,
  input logic [IDX_W-1:0] reg_idx_o,
  input logic [DAT_W-1:0] reg_wdata_o,
  input logic             reg_done_i,
  input logic             blk_req_o
);
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  done_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R7
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(err_pass0_o) && $stable(err_pass1_o) && $stable(err_blk_o)));

  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_o && !reg_done_i) |=>
      (reg_req_o && $stable(reg_we_o) && $stable(reg_idx_o) && $stable(reg_wdata_o)));

  // R2
  read_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_o && !reg_we_o) |-> (reg_idx_o == IDX_W'(2)));

  // R4
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_req_o && blk_req_o));

  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));

  // R4
  req_needs_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_o || blk_req_o) |-> busy_o);
endmodule

bind link_selftest_seq lst_chk #(.CNT_W(CNT_W), .IDX_W(IDX_W), .DAT_W(DAT_W)) i_lst_chk (.*);

// File: tb/test_link_selftest_seq.sv
module test_link_selftest_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       busy, done, fail;
  logic [8:0] e0, e1, eb;
  logic       reg_req, reg_we, reg_space;
  logic [3:0] reg_idx;
  logic [7:0] reg_wdata;
  logic       reg_done = 1'b0;
  logic [7:0] reg_rdata = '0;
  logic       blk_req;
  logic [7:0] blk_addr;
  logic [9:0] blk_len;
  logic       blk_valid = 1'b0;
  logic [7:0] blk_data = '0;

  always #5 clk = ~clk;

  link_selftest_seq i_link_selftest_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .busy_o(busy), .done_o(done), .fail_o(fail),
    .err_pass0_o(e0), .err_pass1_o(e1), .err_blk_o(eb),
    .reg_req_o(reg_req), .reg_we_o(reg_we), .reg_space_o(reg_space),
    .reg_idx_o(reg_idx), .reg_wdata_o(reg_wdata),
    .reg_done_i(reg_done), .reg_rdata_i(reg_rdata),
    .blk_req_o(blk_req), .blk_addr_o(blk_addr), .blk_len_o(blk_len),
    .blk_valid_i(blk_valid), .blk_data_i(blk_data)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // responder state
  logic [7:0]   rf [16];
  logic [255:0] mask0, mask1;
  logic [511:0] bmask;
  int lat = 0, gap = 0;
  int seq_step = 0, seq_bad = 0, acc = 0;
  int blk_seen = 0, blk_bad = 0, overlap = 0, dones = 0;
  bit rsp_busy = 0;
  int rsp_cnt = 0;
  bit bact = 0;
  int bpos = 0, bhold = 0;

  task automatic serve();
    int j, r, i, ph;
    bit ok;
    logic [7:0] kk;
    acc++;
    j = seq_step / 769;
    r = seq_step % 769;
    ok = (reg_space == 1'b0) && (j < 2);
    if (r == 0) ok = ok && reg_we && reg_idx == 4'd6 && reg_wdata == 8'(8'hA0 + 16 * j);
    else begin
      i = (r - 1) / 3;
      ph = (r - 1) % 3;
      if (ph == 0) ok = ok && reg_we && reg_idx == 4'd2 && reg_wdata == (8'(i) ^ 8'hAA);
      else if (ph == 1) ok = ok && reg_we && reg_idx == 4'd3 && reg_wdata == (8'(i) ^ 8'h55);
      else ok = ok && !reg_we && reg_idx == 4'd2;
    end
    if (!ok) seq_bad++;
    seq_step++;
    if (reg_we) rf[reg_idx] = reg_wdata;
    else begin
      kk = rf[2] ^ 8'hAA;
      if ((rf[6] == 8'hA0 && mask0[kk]) || (rf[6] == 8'hB0 && mask1[kk]))
        reg_rdata <= rf[reg_idx] ^ 8'h01;
      else
        reg_rdata <= rf[reg_idx];
    end
  endtask

  always @(posedge clk) begin
    if (reg_done) reg_done <= 1'b0;
    else if (!rsp_busy && reg_req) begin
      rsp_busy <= 1'b1;
      rsp_cnt  <= lat;
    end else if (rsp_busy) begin
      if (rsp_cnt == 0) begin
        serve();
        rsp_busy <= 1'b0;
        reg_done <= 1'b1;
      end else rsp_cnt <= rsp_cnt - 1;
    end
  end

  always @(posedge clk) begin
    blk_valid <= 1'b0;
    if (blk_req) begin
      blk_seen++;
      if (blk_addr != 8'h10 || blk_len != 10'd512) blk_bad++;
      bact  <= 1'b1;
      bpos  <= 0;
      bhold <= 2;
    end else if (bact) begin
      if (bhold > 0) bhold <= bhold - 1;
      else begin
        blk_valid <= 1'b1;
        blk_data  <= 8'(bpos) ^ (bmask[bpos] ? 8'hFF : 8'h00);
        bpos      <= bpos + 1;
        bhold     <= gap;
        if (bpos == 511) bact <= 1'b0;
      end
    end
  end

  // scoreboard
  typedef struct {int e0; int e1; int eb; bit fail;} exp_t;
  exp_t exp_q[$];

  always @(negedge clk) begin
    if (reg_req && bact) overlap++;
    if (done) begin
      dones++;
      if (exp_q.size() == 0) chk(0, "R8", "unexpected done", 1, 0);
      else begin
        exp_t x;
        x = exp_q.pop_front();
        chk(e0 == 9'(x.e0), "R3", "err_pass0", int'(e0), x.e0);
        chk(e1 == 9'(x.e1), "R3", "err_pass1", int'(e1), x.e1);
        chk(eb == 9'(x.eb), "R5", "err_blk", int'(eb), x.eb);
        chk(fail == x.fail, "R6", "fail", int'(fail), int'(x.fail));
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic run(input logic [255:0] m0, input logic [255:0] m1,
                     input logic [511:0] bm, input int l, input int g, input bit poke);
    exp_t x;
    int prev;
    mask0 = m0; mask1 = m1; bmask = bm; lat = l; gap = g;
    for (int i = 0; i < 16; i++) rf[i] = 8'h00;
    seq_step = 0; seq_bad = 0; acc = 0; blk_seen = 0; blk_bad = 0; overlap = 0;
    x.e0 = $countones(m0);
    x.e1 = $countones(m1);
    x.eb = $countones(bm[127:0]);
    x.fail = (x.eb != 0) || (x.e0 != 0 && x.e1 != 0);
    exp_q.push_back(x);
    prev = dones;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy == 1'b1, "R7", "busy after start", int'(busy), 1);
    if (poke) begin
      repeat (200) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (dones == prev) @(negedge clk);
    chk(busy == 1'b0, "R7", "busy at done", int'(busy), 0);
    chk(seq_bad == 0, "R1", "access order errors", seq_bad, 0);
    chk(acc == 1538, "R2", "register accesses", acc, 1538);
    chk(blk_seen == 1 && blk_bad == 0, "R4", "block request count", blk_seen, 1);
    chk(overlap == 0, "R4", "reg request during block", overlap, 0);
    repeat (5) @(negedge clk);
    chk(dones == prev + 1, "R8", "done pulses", dones - prev, 1);
    chk(e0 == 9'(x.e0) && e1 == 9'(x.e1) && eb == 9'(x.eb), "R7", "counters held",
        int'(e0) + int'(e1) + int'(eb), x.e0 + x.e1 + x.eb);
  endtask

  initial begin
    logic [255:0] m;
    logic [511:0] b;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && reg_req == 0 && blk_req == 0, "R7", "reset outputs",
        int'(busy) + int'(done) + int'(reg_req) + int'(blk_req), 0);
    chk(e0 == 0 && e1 == 0 && eb == 0, "R7", "reset counters",
        int'(e0) + int'(e1) + int'(eb), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run('0, '0, '0, 0, 0, 0);                         // R1 R2 clean link
    m = '0;
    for (int k = 3; k < 256; k += 16) m[k] = 1'b1;
    run(m, '0, '0, 1, 1, 0);                          // R3 one noisy pass passes
    run(256'h1F, {1'b1, 255'b0}, '0, 2, 0, 0);         // R6 both passes noisy
    b = '0;
    b[0] = 1'b1; b[127] = 1'b1;
    for (int i = 128; i < 512; i++) b[i] = 1'b1;
    run('0, '0, b, 0, 1, 0);                          // R5 edges of window
    b[0] = 1'b0; b[127] = 1'b0;
    run('0, '0, b, 1, 0, 0);                          // R5 beyond window ignored
    run('0, '1, '0, 0, 0, 1);                         // R3 256 errors, R8 poke
    run('1, '1, '1, 0, 2, 0);                         // R6 everything bad
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule